// File: doc/BRIEF.md
# 64-bit Carry-Select Lookahead Adder/Subtractor

This block adds or subtracts two 64-bit unsigned operands and keeps carry delay short at full width. Each bit pair produces a generate term (AND of the two operand bits) and a propagate term (OR of the two operand bits). Inside each 4-bit group, every carry is formed as one flat sum of products of these terms and the group carry-in, so no carry ripples through the group. The group generate and propagate terms then feed a second flat lookahead level, which spans a 32-bit half.

The low half is added by one 32-bit lookahead adder. The high half is added twice at the same time, once with carry-in 0 and once with carry-in 1. The carry out of the low half then picks one of the two high results through a 2:1 multiplexer, and the other result is dropped. To subtract, the block inverts the second operand and injects a carry-in of 1 at bit 0.

The result and the carry-out are registered once, with a synchronous active-high reset. A caller sees each result on the clock edge after it presents the operands.

Top module: `csla_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, `sum_q` and `cout_q` become 0 on that edge.
- R2: With `sub`=0, the edge after the inputs are presented loads `sum_q` with bits 63..0 of the 65-bit sum `op_a + op_b` and loads `cout_q` with bit 64 of that sum.
- R3: With `sub`=1, the result is `op_a + ~op_b + 1`, taken modulo 2^64. `cout_q`=1 means no borrow, that is `op_a >= op_b` unsigned.
- R4: The speculative high-half result computed with carry-in 1 always equals the one computed with carry-in 0 plus one, modulo 2^32.
- R5: A carry out of bit 31 reaches the high half. For example, 0x00000000FFFFFFFF + 1 gives 0x0000000100000000 with `cout_q`=0.
- R6: All-ones + 1 gives `sum_q`=0 and `cout_q`=1.
- R7: 0 - 1 gives all ones and `cout_q`=0.
- R8: Subtracting any value from itself gives `sum_q`=0 and `cout_q`=1. Subtracting 0 always gives `cout_q`=1.
- R9: The carry out of the low 32-bit adder equals bit 32 of the behavioural sum of the low halves plus the injected carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand, inverted when subtracting |
| sub | input | 1 | 1 = subtract, 0 = add |
| sum_q | output | 64 | Registered result |
| cout_q | output | 1 | Registered carry-out (1 = no borrow when subtracting) |

## Verification
The arithmetic between the ports is purely combinational, and there is one register stage, so each sum and carry-out is due exactly one rising edge after its operands are applied. The bench changes the inputs on a falling edge and reads the outputs on the next falling edge. That puts every check half a cycle after the edge that loaded the result and before the next operands can reach the register. The expected 65-bit value for each check is computed in the bench from the operands alone. The checks for reset and for carries crossing bit 31 are timed the same way.

// File: rtl/csla_pkg.sv
package csla_pkg;
  // Default sizing shared by the adder hierarchy.
  parameter int unsigned CSLA_WIDTH = 64;
  parameter int unsigned CSLA_GROUP = 4;
endpackage

// File: rtl/cla_lcu.sv
// Flat lookahead unit: every carry is a single AND-then-OR of g/p terms.
module cla_lcu #(
  parameter int N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         cin,
  output logic [N-1:0] c,   // c[j] = carry into position j
  output logic         gg,
  output logic         gp
);

  // carries into each position, expanded with no chain
  always_comb begin
    logic term;
    logic prod;
    for (int j = 0; j < N; j++) begin
      term = cin;
      for (int m = 0; m < j; m++) term = term & p[m];
      for (int k = 0; k < j; k++) begin
        prod = g[k];
        for (int m = k + 1; m < j; m++) prod = prod & p[m];
        term = term | prod;
      end
      c[j] = term;
    end
  end

  // block generate/propagate, independent of cin
  always_comb begin
    logic prod;
    gg = 1'b0;
    for (int k = 0; k < N; k++) begin
      prod = g[k];
      for (int m = k + 1; m < N; m++) prod = prod & p[m];
      gg = gg | prod;
    end
    gp = &p;
  end

endmodule

// File: rtl/cla_block.sv
// Two-level lookahead adder: GROUP-bit groups, then a group-level unit.
module cla_block #(
  parameter int W     = 32,
  parameter int GROUP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int NG = W / GROUP;

  logic [W-1:0]  bit_g, bit_p, bit_x, bit_c;
  logic [NG-1:0] grp_g, grp_p, grp_c;
  logic          blk_g, blk_p;

  assign bit_g = a & b;
  assign bit_p = a | b;
  assign bit_x = a ^ b;

  cla_lcu #(.N(NG)) u_top (
    .g  (grp_g),
    .p  (grp_p),
    .cin(cin),
    .c  (grp_c),
    .gg (blk_g),
    .gp (blk_p)
  );

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    cla_lcu #(.N(GROUP)) u_grp (
      .g  (bit_g[gi*GROUP +: GROUP]),
      .p  (bit_p[gi*GROUP +: GROUP]),
      .cin(grp_c[gi]),
      .c  (bit_c[gi*GROUP +: GROUP]),
      .gg (grp_g[gi]),
      .gp (grp_p[gi])
    );
  end

  assign sum  = bit_x ^ bit_c;
  assign cout = blk_g | (blk_p & cin);

endmodule

// File: rtl/csla_addsub.sv
module csla_addsub
  import csla_pkg::*;
#(
  parameter int WIDTH = CSLA_WIDTH,
  parameter int GROUP = CSLA_GROUP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] b_eff;
  logic [HALF-1:0]  lo_sum, hi0_sum, hi1_sum, hi_sel;
  logic             lo_cout, hi0_cout, hi1_cout, hi_cout;

  assign b_eff = sub ? ~op_b : op_b;

  cla_block #(.W(HALF), .GROUP(GROUP)) u_lo (
    .a(op_a[HALF-1:0]), .b(b_eff[HALF-1:0]), .cin(sub),
    .sum(lo_sum), .cout(lo_cout)
  );

  // speculative high halves
  cla_block #(.W(HALF), .GROUP(GROUP)) u_hi0 (
    .a(op_a[WIDTH-1:HALF]), .b(b_eff[WIDTH-1:HALF]), .cin(1'b0),
    .sum(hi0_sum), .cout(hi0_cout)
  );

  cla_block #(.W(HALF), .GROUP(GROUP)) u_hi1 (
    .a(op_a[WIDTH-1:HALF]), .b(b_eff[WIDTH-1:HALF]), .cin(1'b1),
    .sum(hi1_sum), .cout(hi1_cout)
  );

  assign hi_sel  = lo_cout ? hi1_sum  : hi0_sum;
  assign hi_cout = lo_cout ? hi1_cout : hi0_cout;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= {hi_sel, lo_sum};
      cout_q <= hi_cout;
    end
  end

  // ---------------- assertions ----------------
  logic [WIDTH:0] ref_full;
  logic [HALF:0]  ref_lo;
  assign ref_full = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
  assign ref_lo   = {1'b0, op_a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, sub};

  // R2 / R3: registered result matches a behavioural 65-bit sum
  assert_result_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {cout_q, sum_q} == $past(ref_full));

  // R4: the two speculative halves differ by exactly one
  assert_spec_pair_R4: assert property (@(posedge clk) disable iff (rst)
    hi1_sum == hi0_sum + HALF'(1));

  // R9: low-half carry matches behavioural low sum
  assert_lo_carry_R9: assert property (@(posedge clk) disable iff (rst)
    lo_cout == ref_lo[HALF]);

  // R8: subtracting zero never borrows
  assert_sub_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (sub && op_b == '0) |=> cout_q);

  // R8: a - a yields zero with no borrow
  assert_self_sub_R8: assert property (@(posedge clk) disable iff (rst)
    (sub && op_a == op_b) |=> (sum_q == '0 && cout_q));

endmodule

// File: tb/csla_addsub_test.sv
module csla_addsub_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic        sub = 1'b0;
  logic [63:0] sum_q;
  logic        cout_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  csla_addsub uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .sub(sub),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  // Reference model: operands in, expected 65-bit value out.
  function automatic logic [64:0] model(input logic [63:0] a, input logic [63:0] b, input logic s);
    logic [64:0] r;
    if (s) r = {1'b0, a} + {1'b0, ~b} + 65'd1;
    else   r = {1'b0, a} + {1'b0, b};
    return r;
  endfunction

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
               req, got[64], got[63:0], exp[64], exp[63:0]);
    end
  endtask

  // Drive at a falling edge, result due after the next rising edge.
  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b, input logic s);
    @(negedge clk);
    op_a = a; op_b = b; sub = s;
    @(negedge clk);
    check(req, {cout_q, sum_q}, model(a, b, s));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with nonzero operands present
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1;
    repeat (3) @(negedge clk);
    check("R1", {cout_q, sum_q}, 65'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {cout_q, sum_q}, 65'd0);
    rst = 1'b0;

    // R2: plain additions
    apply("R2", 64'd5, 64'd7, 1'b0);
    apply("R2", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    apply("R2", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0);
    // R6: all ones + 1
    apply("R6", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    // R5: carry crossing bit 31
    apply("R5", 64'h0000_0000_FFFF_FFFF, 64'd1, 1'b0);
    apply("R5", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5556, 1'b0);
    apply("R5", 64'h5555_5555_AAAA_AAAA, 64'hAAAA_AAAA_5555_5556, 1'b0);
    apply("R9", 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b0);
    // R7: 0 - 1
    apply("R7", 64'd0, 64'd1, 1'b1);
    // R3: subtraction with and without borrow
    apply("R3", 64'd100, 64'd42, 1'b1);
    apply("R3", 64'd42, 64'd100, 1'b1);
    apply("R3", 64'h0000_0001_0000_0000, 64'd1, 1'b1);
    // R8: self subtraction and subtracting zero
    apply("R8", 64'hDEAD_BEEF_CAFE_F00D, 64'hDEAD_BEEF_CAFE_F00D, 1'b1);
    apply("R8", 64'h0, 64'h0, 1'b1);
    // R4: alternating upper patterns selected both ways
    apply("R4", 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_FFFF_FFFF, 1'b0);
    apply("R4", 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);

    // R2/R3: random vectors, back-to-back
    for (int i = 0; i < 300; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 5 == 0) rb = ~ra;
      apply((i % 2) ? "R3" : "R2", ra, rb, logic'(i % 2));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule